// File: doc/BRIEF.md
# Dual-Exposure Glare Fusion Filter

This block merges two co-registered luminance rows of the same scene, one taken with a long exposure and one with a short exposure, so that glare halos around bright sources are suppressed. For each position, the long-exposure sample is kept unless it reaches a programmable brightness threshold. In that case the sample counts as saturated, and the short-exposure sample at the same position is used in its place. The fused value and a per-pixel substitution flag are written into a row buffer.

When the whole row has been stored, the block streams it back out in input order. Each substituted pixel is replaced by the truncated mean of a centred window of fused values, at most seven wide. Near either row end the window shrinks to the neighbours that exist. Pixels that were not substituted leave unchanged. Input and output both use valid/ready handshakes. The output carries markers for the first and last pixel of the row.

Top module: `glare_fuse_row`

## Requirements
- R1: A long-exposure value below THRESH (default 245) is stored unchanged as the fused value.
- R2: A long-exposure value of THRESH or more is discarded, and the short-exposure value at the same position becomes the fused value and is flagged as substituted (244 is kept, 245 is substituted).
- R3: `in_ready` is high while the row is being filled. No output is offered until all ROW_LEN pixels have been accepted. After the last accepted input, `in_ready` goes low and `out_valid` rises on the next cycle.
- R4: A substituted pixel at least three positions from both row ends is output as floor(sum of the 7 fused values centred on it / 7).
- R5: A substituted pixel within three positions of a row end averages only the positions that exist inside the row. The divisor is the actual sample count (4, 5 or 6), and the result is truncated.
- R6: A pixel that was not substituted is output equal to its fused value, even when its neighbours were substituted.
- R7: The averaging inputs are the fused values, so substituted neighbours contribute their short-exposure value.
- R8: Output order equals input order. `out_sor` is high only with the first pixel and `out_eor` only with the last. After the last handshake the block returns to filling.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pix`, `out_sor` and `out_eor` hold their values.
- R10: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel pair valid |
| in_ready | output | 1 | Block accepts an input pair |
| in_long | input | 8 | Long-exposure luminance |
| in_short | input | 8 | Short-exposure luminance at the same position |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | 8 | Fused, smoothed luminance |
| out_sor | output | 1 | First pixel of the row |
| out_eor | output | 1 | Last pixel of the row |

## Verification
The assertions assume that the downstream side may hold `out_ready` low for any length of time. They also assume that the upstream side presents an input pair only as a row of exactly ROW_LEN handshakes, with no partial row abandoned. The bench always sends complete rows. It drives inputs only at falling edges, and it stalls the output side on chosen pixels so that the hold property is exercised. Threshold-boundary values, halos at both row ends and fully saturated rows keep every window width and both fusion choices inside the checked behaviour.

// File: rtl/glare_fuse_row.sv
module glare_fuse_row #(
  parameter int ROW_LEN = 640,
  parameter int THRESH  = 245
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_long,
  input  logic [7:0] in_short,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_pix,
  output logic       out_sor,
  output logic       out_eor
);
  localparam int IW = (ROW_LEN > 1) ? $clog2(ROW_LEN) : 1;
  localparam logic [IW-1:0] LAST = IW'(ROW_LEN - 1);

  logic [7:0]         row_px [ROW_LEN];
  logic [ROW_LEN-1:0] sub_flag;
  logic [IW-1:0]      idx;
  logic               draining;
  logic               hot;
  logic               take, give;
  logic [10:0]        acc;
  logic [10:0]        cnt;
  logic [10:0]        avg;

  assign hot       = (int'(in_long) >= THRESH);
  assign in_ready  = !draining;
  assign out_valid = draining;
  assign take      = in_valid && in_ready;
  assign give      = out_valid && out_ready;
  assign out_sor   = draining && (idx == '0);
  assign out_eor   = draining && (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      draining <= 1'b0;
    end else if (take || give) begin
      if (idx == LAST) begin
        idx      <= '0;
        draining <= take;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      row_px[idx]   <= hot ? in_short : in_long;
      sub_flag[idx] <= hot;
    end
  end

  always_comb begin
    int p;
    acc = '0;
    cnt = '0;
    for (int k = -3; k <= 3; k++) begin
      p = int'(idx) + k;
      if (p >= 0 && p < ROW_LEN) begin
        acc = acc + {3'b000, row_px[p[IW-1:0]]};
        cnt = cnt + 11'd1;
      end
    end
    avg = acc / cnt;
  end

  assign out_pix = sub_flag[idx] ? avg[7:0] : row_px[idx];

  a_r3_drain_follows_row: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx == LAST) |=> (out_valid && out_sor));
  a_r3_stop_accepting: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx == LAST) |=> !in_ready);
  a_r8_refill_after_eor: assert property (@(posedge clk) disable iff (!rst_n)
    (give && out_eor) |=> (in_ready && !out_valid));
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_sor) && $stable(out_eor)));
endmodule

// File: tb/glare_fuse_row_test.sv
`timescale 1ns/1ps
module glare_fuse_row_test;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_long = '0, in_short = '0;
  logic in_ready, out_valid, out_sor, out_eor;
  logic [7:0] out_pix;
  int checks = 0, fails = 0;
  int lg [N];
  int sh [N];

  always #2.5 clk = ~clk;

  glare_fuse_row #(.ROW_LEN(N), .THRESH(245)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_long(in_long), .in_short(in_short), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix), .out_sor(out_sor), .out_eor(out_eor));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fused(int i);
    return (lg[i] >= 245) ? sh[i] : lg[i];
  endfunction

  function automatic int expect_pix(int i);
    int s = 0, c = 0;
    if (lg[i] < 245) return lg[i];
    for (int j = i - 3; j <= i + 3; j++)
      if (j >= 0 && j < N) begin s += fused(j); c++; end
    return s / c;
  endfunction

  task automatic run_row(string tag, int stall);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      check("R3 in_ready during fill", in_ready, 1);
      check("R3 no output during fill", out_valid, 0);
      in_valid = 1'b1; in_long = 8'(lg[i]); in_short = 8'(sh[i]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 in_ready low after row", in_ready, 0);
    check("R3 out_valid after row", out_valid, 1);
    for (int i = 0; i < N; i++) begin
      if (stall != 0 && (i % 3 == 1)) begin
        int held;
        out_ready = 1'b0;
        held = out_pix;
        @(negedge clk);
        check("R9 valid held", out_valid, 1);
        check("R9 pix held", out_pix, held);
      end
      out_ready = 1'b1;
      check("R8 valid", out_valid, 1);
      check({tag, " pix"}, out_pix, expect_pix(i));
      check("R8 sor", out_sor, (i == 0) ? 1 : 0);
      check("R8 eor", out_eor, (i == N - 1) ? 1 : 0);
      @(negedge clk);
    end
    out_ready = 1'b0;
    check("R8 back to fill", in_ready, 1);
    check("R8 idle after row", out_valid, 0);
  endtask

  task automatic t_dark();
    for (int i = 0; i < N; i++) begin lg[i] = 10 * i; sh[i] = 3; end
    run_row("R1", 0);
  endtask

  task automatic t_boundary();
    for (int i = 0; i < N; i++) begin lg[i] = (i % 2 == 0) ? 244 : 245; sh[i] = 20 + i; end
    run_row("R2", 0);
  endtask

  task automatic t_mid_halo();
    for (int i = 0; i < N; i++) begin lg[i] = 100 + i; sh[i] = 7 * i; end
    lg[7] = 250; lg[8] = 255; lg[10] = 246;
    run_row("R4 R6 R7", 1);
  endtask

  task automatic t_edge_halo();
    for (int i = 0; i < N; i++) begin lg[i] = 60 + 2 * i; sh[i] = 200 - 5 * i; end
    lg[0] = 255; lg[1] = 249; lg[2] = 245; lg[N-1] = 252; lg[N-2] = 247; lg[N-3] = 245;
    run_row("R5", 1);
  endtask

  task automatic t_all_halo();
    for (int i = 0; i < N; i++) begin lg[i] = 255; sh[i] = (i * 37) % 256; end
    run_row("R4 R5 R7", 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 in_ready after reset", in_ready, 1);
    check("R10 out_valid after reset", out_valid, 0);
    t_dark();
    t_boundary();
    t_mid_halo();
    t_edge_halo();
    t_all_halo();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule